// File: doc/BRIEF.md
# Second-Order Sigma-Delta Modulator

This block turns a signed multi-bit sample stream into a single-bit stream whose density follows the input. The quantization error is pushed towards high frequencies by a (1 - z^-1)^2 shaping function. The loop has two delaying accumulators in series. Each accumulator adds half of the difference between its input and the fed-back level. A two-level comparator on the second accumulator closes the loop, and its decision selects plus or minus full scale as the feedback level.

Three non-idealities can be enabled by parameter so that their effect on the loop can be studied:

- a finite-gain leak on both accumulators;
- saturation of both accumulators to a programmable magnitude;
- comparator hysteresis around the last decision.

A sticky flag per accumulator records that saturation has occurred.

Top module: `sdm2_top`

## Requirements
- R1: While `rst` is high, both accumulators are cleared, the decision register is cleared, and both clip flags are cleared. In the cycle after reset, `bitOut` is 0 and both flags are 0.
- R2: A clock edge with `sampleEn` low leaves the accumulators, the decision and the flags unchanged, whatever value `sampleIn` has.
- R3: On each enabled edge, the feedback level fb depends on the present decision. The accumulators then update as follows, where `>>>1` is an arithmetic shift that rounds towards minus infinity:
  - i1 <= i1 + ((x - fb) >>> 1)
  - i2 <= i2 + ((i1_present - fb) >>> 1)
- R4: The feedback level is +2^(IN_W-1) when the decision is 1 and -2^(IN_W-1) when it is 0. `bitOut` is the decision register, so a 1 means plus full scale.
- R5: For a constant input x, the mean of the output mapped to ±1 over 4096 enabled samples lies within 0.01 of x / 2^(IN_W-1).
- R6: With LEAK_K > 0, the stored state of each accumulator is scaled by 1 - 2^-LEAK_K before the new term is added, computed as s - (s >>> LEAK_K). LEAK_K = 0 means no leak.
- R7: Each updated accumulator value is limited to the range [-CLIP_LIM, +CLIP_LIM].
- R8: A clip flag is set on the enabled edge where its accumulator's unclipped sum falls outside that range. The flag stays set until reset.
- R9: The decision compares the present i2 against a threshold that depends on the last decision. From 0 it moves to 1 only when i2 > HYST. From 1 it moves to 0 only when i2 < -HYST. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | Advances the loop by one sample on this edge |
| sampleIn | input | IN_W | Signed input sample |
| bitOut | output | 1 | Current one-bit decision |
| clipFlag1 | output | 1 | Sticky: first accumulator has saturated |
| clipFlag2 | output | 1 | Sticky: second accumulator has saturated |

## Verification
The bench builds four copies of the block side by side with IN_W = 12 and ACC_W = 16, all fed the same stimulus:

| Copy | Setting | What it exercises |
|---|---|---|
| Ideal | saturation out of reach, no leak, no hysteresis | plain loop equations and DC density |
| Leaky | LEAK_K = 4 | shift-subtract leak on both accumulators |
| Clipping | CLIP_LIM = 600 | saturation and the sticky flags, reachable with moderate inputs |
| Hysteresis | HYST = 400 | held decisions near zero |

Every output bit and flag of all four copies is compared against a bit-accurate loop model. Stalls with a changing input confirm that nothing moves while the enable is low.

// File: rtl/sdm2_pkg.sv
package sdm2_pkg;
  // Strobes from the control block to the accumulator datapath.
  typedef struct packed {
    logic adv;     // advance the loop on this edge
    logic fbHigh;  // feedback level is plus full scale
  } sdmStrobe_t;
endpackage

// File: rtl/sdm2_integ.sv
module sdm2_integ #(
  parameter int ACC_W    = 16,
  parameter int SUM_W    = 19,
  parameter int LEAK_K   = 0,
  parameter int CLIP_LIM = 32767
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic signed [SUM_W-1:0] diffIn,
  output logic signed [ACC_W-1:0] state,
  output logic                    clipHit
);
  localparam logic signed [SUM_W-1:0] LIM_S = SUM_W'(CLIP_LIM);

  logic signed [SUM_W-1:0] cur, kept, halfDiff, preSum, clipped;
  logic                    over;

  assign cur      = {{(SUM_W-ACC_W){state[ACC_W-1]}}, state};
  assign halfDiff = diffIn >>> 1;

  generate
    if (LEAK_K == 0) begin : g_noLeak
      assign kept = cur;
    end else begin : g_leak
      assign kept = cur - (cur >>> LEAK_K);
    end
  endgenerate

  assign preSum = kept + halfDiff;

  always_comb begin
    over    = 1'b0;
    clipped = preSum;
    if (preSum > LIM_S) begin
      clipped = LIM_S;
      over    = 1'b1;
    end else if (preSum < -LIM_S) begin
      clipped = -LIM_S;
      over    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= '0;
      clipHit <= 1'b0;
    end else if (adv) begin
      state <= clipped[ACC_W-1:0];
      if (over) clipHit <= 1'b1;
    end
  end

  // R7
  range_lim_chk: assert property (@(posedge clk) disable iff (rst)
    (cur <= LIM_S) && (cur >= -LIM_S));
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    clipHit |=> clipHit);
  // R2
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state) && $stable(clipHit));
endmodule

// File: rtl/sdm2_path.sv
module sdm2_path
  import sdm2_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int ACC_W    = 16,
  parameter int LEAK_K   = 0,
  parameter int CLIP_LIM = 32767
) (
  input  logic                    clk,
  input  logic                    rst,
  input  sdmStrobe_t              stb,
  input  logic signed [IN_W-1:0]  sampleIn,
  output logic signed [ACC_W-1:0] secondState,
  output logic                    clip1,
  output logic                    clip2
);
  localparam int SUM_W = ACC_W + 3;
  localparam logic signed [SUM_W-1:0] FS = SUM_W'(1) <<< (IN_W - 1);

  logic signed [SUM_W-1:0] fbLevel, xExt;
  logic signed [SUM_W-1:0] diffV [2];
  logic signed [ACC_W-1:0] stateV [2];
  logic                    hitV [2];

  assign fbLevel  = stb.fbHigh ? FS : -FS;
  assign xExt     = {{(SUM_W-IN_W){sampleIn[IN_W-1]}}, sampleIn};
  assign diffV[0] = xExt - fbLevel;
  assign diffV[1] = {{(SUM_W-ACC_W){stateV[0][ACC_W-1]}}, stateV[0]} - fbLevel;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_stage
      sdm2_integ #(
        .ACC_W(ACC_W), .SUM_W(SUM_W), .LEAK_K(LEAK_K), .CLIP_LIM(CLIP_LIM)
      ) u_integ (
        .clk(clk), .rst(rst), .adv(stb.adv),
        .diffIn(diffV[g]), .state(stateV[g]), .clipHit(hitV[g])
      );
    end
  endgenerate

  assign secondState = stateV[1];
  assign clip1       = hitV[0];
  assign clip2       = hitV[1];
endmodule

// File: rtl/sdm2_ctrl.sv
module sdm2_ctrl
  import sdm2_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int HYST  = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sampleEn,
  input  logic signed [ACC_W-1:0] secondState,
  output sdmStrobe_t              stb,
  output logic                    decision
);
  localparam logic signed [ACC_W-1:0] H_S = ACC_W'(HYST);

  logic decNext;

  always_comb begin
    if (decision) decNext = !(secondState < -H_S);
    else          decNext = (secondState > H_S);
  end

  always_ff @(posedge clk) begin
    if (rst)           decision <= 1'b0;
    else if (sampleEn) decision <= decNext;
  end

  assign stb.adv    = sampleEn;
  assign stb.fbHigh = decision;

  // R1
  reset_dec_chk: assert property (@(posedge clk) rst |=> (decision == 1'b0));
  // R9
  rise_thresh_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(decision) |-> ($past(secondState) > H_S));
  // R9
  fall_thresh_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(decision) |-> ($past(secondState) < -H_S));
  // R2
  hold_dec_chk: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> $stable(decision));
endmodule

// File: rtl/sdm2_top.sv
module sdm2_top
  import sdm2_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int ACC_W    = 16,
  parameter int LEAK_K   = 0,
  parameter int CLIP_LIM = 32767,
  parameter int HYST     = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sampleEn,
  input  logic signed [IN_W-1:0] sampleIn,
  output logic                   bitOut,
  output logic                   clipFlag1,
  output logic                   clipFlag2
);
  sdmStrobe_t              stb;
  logic signed [ACC_W-1:0] secondState;

  sdm2_ctrl #(.ACC_W(ACC_W), .HYST(HYST)) u_ctrl (
    .clk(clk), .rst(rst), .sampleEn(sampleEn),
    .secondState(secondState), .stb(stb), .decision(bitOut)
  );

  sdm2_path #(
    .IN_W(IN_W), .ACC_W(ACC_W), .LEAK_K(LEAK_K), .CLIP_LIM(CLIP_LIM)
  ) u_path (
    .clk(clk), .rst(rst), .stb(stb), .sampleIn(sampleIn),
    .secondState(secondState), .clip1(clipFlag1), .clip2(clipFlag2)
  );
endmodule

// File: tb/sdm2_top_tb.sv
`timescale 1ns/1ps
module sdm2_top_tb;
  localparam int IN_W = 12;
  localparam int ACC_W = 16;
  localparam longint FS = 2048;
  localparam int NCFG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic signed [IN_W-1:0] sIn = '0;
  logic bo [NCFG];
  logic f1 [NCFG];
  logic f2 [NCFG];

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // config: 0 ideal, 1 leaky, 2 clipping, 3 hysteresis
  int cfgK [NCFG] = '{0, 4, 0, 0};
  longint cfgLim [NCFG] = '{32767, 32767, 600, 32767};
  longint cfgH [NCFG] = '{0, 0, 0, 400};
  string cfgTag [NCFG] = '{"R3", "R6", "R7", "R9"};

  longint m1 [NCFG];
  longint m2 [NCFG];
  bit md [NCFG];
  bit mc1 [NCFG];
  bit mc2 [NCFG];

  always #10 clk = ~clk;

  sdm2_top #(.IN_W(IN_W), .ACC_W(ACC_W)) u_dut (
    .clk(clk), .rst(rst), .sampleEn(en), .sampleIn(sIn),
    .bitOut(bo[0]), .clipFlag1(f1[0]), .clipFlag2(f2[0]));
  sdm2_top #(.IN_W(IN_W), .ACC_W(ACC_W), .LEAK_K(4)) u_leak (
    .clk(clk), .rst(rst), .sampleEn(en), .sampleIn(sIn),
    .bitOut(bo[1]), .clipFlag1(f1[1]), .clipFlag2(f2[1]));
  sdm2_top #(.IN_W(IN_W), .ACC_W(ACC_W), .CLIP_LIM(600)) u_clip (
    .clk(clk), .rst(rst), .sampleEn(en), .sampleIn(sIn),
    .bitOut(bo[2]), .clipFlag1(f1[2]), .clipFlag2(f2[2]));
  sdm2_top #(.IN_W(IN_W), .ACC_W(ACC_W), .HYST(400)) u_hys (
    .clk(clk), .rst(rst), .sampleEn(en), .sampleIn(sIn),
    .bitOut(bo[3]), .clipFlag1(f1[3]), .clipFlag2(f2[3]));

  function automatic longint leakF(longint s, int k);
    return (k == 0) ? s : s - (s >>> k);
  endfunction

  task automatic modelReset();
    for (int c = 0; c < NCFG; c++) begin
      m1[c] = 0; m2[c] = 0; md[c] = 0; mc1[c] = 0; mc2[c] = 0;
    end
  endtask

  task automatic modelStep(input longint x, input bit adv);
    for (int c = 0; c < NCFG; c++) begin
      longint fb, p1, p2;
      bit nd;
      if (adv) begin
        fb = md[c] ? FS : -FS;
        p1 = leakF(m1[c], cfgK[c]) + ((x - fb) >>> 1);
        p2 = leakF(m2[c], cfgK[c]) + ((m1[c] - fb) >>> 1);
        if (p1 > cfgLim[c]) begin p1 = cfgLim[c]; mc1[c] = 1; end
        else if (p1 < -cfgLim[c]) begin p1 = -cfgLim[c]; mc1[c] = 1; end
        if (p2 > cfgLim[c]) begin p2 = cfgLim[c]; mc2[c] = 1; end
        else if (p2 < -cfgLim[c]) begin p2 = -cfgLim[c]; mc2[c] = 1; end
        nd = md[c] ? !(m2[c] < -cfgH[c]) : (m2[c] > cfgH[c]);
        m1[c] = p1; m2[c] = p2; md[c] = nd;
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic compareAll(input string tag);
    for (int c = 0; c < NCFG; c++) begin
      check(bo[c] == md[c] && f1[c] == mc1[c] && f2[c] == mc2[c],
            (tag == "") ? cfgTag[c] : tag,
            $sformatf("cfg%0d bit/clip1/clip2 actual %0b%0b%0b expected %0b%0b%0b",
                      c, bo[c], f1[c], f2[c], md[c], mc1[c], mc2[c]));
    end
  endtask

  task automatic step(input longint x, input bit adv, input string tag);
    @(negedge clk);
    sIn = x[IN_W-1:0];
    en = adv;
    @(posedge clk);
    #1;
    modelStep(x, adv);
    compareAll(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  task automatic testReset();
    doReset();
    #1;
    for (int c = 0; c < NCFG; c++)
      check(bo[c] == 0 && f1[c] == 0 && f2[c] == 0, "R1",
            $sformatf("cfg%0d after reset actual %0b%0b%0b expected 000",
                      c, bo[c], f1[c], f2[c]));
  endtask

  task automatic testDc(input longint x, input int n);
    for (int i = 0; i < n; i++) step(x, 1'b1, "");
  endtask

  task automatic testRamp();
    for (int i = 0; i < 300; i++) step(((i * 37) % 3000) - 1500, 1'b1, "");
  endtask

  task automatic testHold();
    bit snap [NCFG];
    testDc(333, 50);
    for (int c = 0; c < NCFG; c++) snap[c] = bo[c];
    for (int i = 0; i < 16; i++) begin
      step(((i * 511) % 4000) - 2000, 1'b0, "R2");
      for (int c = 0; c < NCFG; c++)
        check(bo[c] == snap[c], "R2",
              $sformatf("cfg%0d stalled bit actual %0b expected %0b", c, bo[c], snap[c]));
    end
    testDc(333, 50);
  endtask

  task automatic testAverage(input longint x);
    longint sum;
    real avg, want;
    doReset();
    sum = 0;
    for (int i = 0; i < 4096; i++) begin
      step(x, 1'b1, "");
      sum += bo[0] ? 1 : -1;
    end
    avg = real'(sum) / 4096.0;
    want = real'(x) / real'(FS);
    check((avg - want < 0.01) && (want - avg < 0.01), "R5",
          $sformatf("mean for x=%0d actual %f expected %f", x, avg, want));
    if (x != 0)
      check((x > 0) == (sum > 0), "R4",
            $sformatf("density sign for x=%0d actual sum %0d", x, sum));
  endtask

  task automatic testSticky();
    doReset();
    testDc(1900, 40);
    check(f1[2] == 1 && f2[2] == 1, "R8",
          $sformatf("clip flags after large input actual %0b%0b expected 11", f1[2], f2[2]));
    testDc(0, 40);
    check(f1[2] == 1 && f2[2] == 1, "R8",
          $sformatf("clip flags after small input actual %0b%0b expected 11", f1[2], f2[2]));
    testReset();
  endtask

  initial begin
    testReset();
    testDc(0, 100);
    testDc(700, 200);
    testDc(-1500, 200);
    testRamp();
    testHold();
    testSticky();
    testAverage(1024);
    testAverage(-700);
    testAverage(0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule